// File: doc/BRIEF.md
# Four-Channel DAC Serial Command Core

This block is the digital front end of a four-channel, 10-bit digital-to-analog converter. A host writes 16-bit command frames over a three-wire serial link: an active-low select, a serial clock and a data line. All three pins are oversampled in one system clock. Each frame is shifted in most significant bit first. The frame is decoded when the select line returns high. Every channel has a staged (input) code and a live (output) code, so the host can stage new values and then switch all channels at once.

The decoded commands do the following:
- load a single staged code, with or without a global transfer;
- write one code to every channel;
- transfer all staged codes to the live codes;
- set or clear a general-purpose logic output;
- choose on which serial clock edge the echo output changes;
- enter a low-power sleep state.

A lockout pin can veto sleep. A falling edge on that pin wakes a sleeping block. The echo output shows the top bit of the shift register, so devices can be chained. The four live codes and the sleep flag are the outputs that drive the analog side.

Top module: `qdac_ctrl`

## Requirements
- R1: A frame is 16 bits, MSB first: address in bits 15:14 (channel A = 0 … D = 3), control in bits 13:12, code in bits 11:2, sub-bits in 1:0. Control 01 loads the addressed staged code and leaves every live code unchanged.
- R2: Control 11 loads the addressed staged code, then copies all four staged codes, including the new one, to the live codes.
- R3: Bits 15:12 = 0100 copies all staged codes to the live codes and clears sleep. Bits 15:12 = 1000 writes the code field into every staged and live code and clears sleep.
- R4: Bits 15:12 = 1100 sets sleep only while the lockout pin is high; with the pin low it has no effect. During sleep, frames are still received and staged codes are kept.
- R5: A high-to-low transition of the lockout pin clears sleep, and the live codes keep their values.
- R6: Bits 15:12 = 0010 drives the logic output low and 0110 drives it high. Bits 15:12 = 0000 changes nothing.
- R7: Bits 15:12 = 1010 selects rising-edge echo and 1110 selects falling-edge echo. Both also copy all staged codes to the live codes.
- R8: The echo output is the shift register MSB. In rising-edge mode it changes after each serial clock rise (16-clock lag). In falling-edge mode it is captured on each serial clock fall (16.5-clock lag).
- R9: Bits shift in only on serial clock rises while select is low. A frame that ends after any count other than 16 rises changes no register or output.
- R10: The asynchronous active-low clear zeroes all staged and live codes, the logic output, sleep and the echo output, and selects falling-edge echo.
- R11: The two sub-bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sclk_i | input | 1 | Serial clock |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| lock_n_i | input | 1 | Sleep permit; a falling edge wakes the block |
| sdo_o | output | 1 | Serial echo output |
| upo_o | output | 1 | General-purpose logic output |
| sleep_o | output | 1 | Sleep flag |
| chan_code_o | output | 40 | Live codes, channel A in bits 9:0 up to D in 39:30 |

## Verification
The bench aims at the load-and-transfer command. A design that transferred before loading would leave the addressed live code one write behind. It sends frames of 15 and 17 bits, which a design without an exact bit count would execute. It toggles the lockout pin around the sleep command, because a gate or wake path wired the wrong way either sleeps when vetoed or never wakes. It checks the echo value at mid-phase of the first serial clock of every frame, which separates the half-cycle lag of falling-edge mode from the full-cycle lag of rising-edge mode.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_BITS = 16;
  localparam int SUB_BITS   = 2;
  localparam int CMD_W      = FRAME_BITS - SUB_BITS;  // bits kept after sub-bits
  localparam int CODE_W     = 10;
  localparam int CH_NUM     = 4;
  localparam int ADDR_W     = $clog2(CH_NUM);

  typedef enum logic [3:0] {
    OP_NOP,
    OP_LOAD_IN,
    OP_LOAD_UPD,
    OP_UPDATE,
    OP_BCAST,
    OP_SLEEP,
    OP_UPO_LO,
    OP_UPO_HI,
    OP_MODE_RISE,
    OP_MODE_FALL
  } op_e;

  // cmd layout: [13:12] address, [11:10] control, [9:0] code
  function automatic logic [ADDR_W-1:0] addr_of(input logic [CMD_W-1:0] cmd);
    return cmd[CMD_W-1 -: ADDR_W];
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input logic [CMD_W-1:0] cmd);
    return cmd[CODE_W-1:0];
  endfunction

  function automatic op_e op_of(input logic [CMD_W-1:0] cmd);
    logic [3:0] ac;
    ac = cmd[CMD_W-1 -: 4];
    if (ac[1:0] == 2'b01) return OP_LOAD_IN;
    if (ac[1:0] == 2'b11) return OP_LOAD_UPD;
    case (ac)
      4'b0100: return OP_UPDATE;
      4'b1000: return OP_BCAST;
      4'b1100: return OP_SLEEP;
      4'b0010: return OP_UPO_LO;
      4'b0110: return OP_UPO_HI;
      4'b1010: return OP_MODE_RISE;
      4'b1110: return OP_MODE_FALL;
      default: return OP_NOP;
    endcase
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[k] <= RST_VAL;
          else        pipe[k] <= pipe[k-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
  import qdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             cs_high,
  input  logic             cs_rise,
  input  logic             sdi,
  input  logic             mode_rise,
  output logic [CMD_W-1:0] cmd_o,
  output logic             frame_ok_o,
  output logic             sdo_o
);
  localparam int CNT_MAX = FRAME_BITS + 1;  // saturates one past a full frame
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_high) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], sdi};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fall_q <= 1'b0;
    else if (sclk_fall) fall_q <= shreg[FRAME_BITS-1];
  end

  assign frame_ok_o = cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));
  assign cmd_o      = shreg[FRAME_BITS-1:SUB_BITS];
  assign sdo_o      = mode_rise ? shreg[FRAME_BITS-1] : fall_q;
endmodule

// File: rtl/qdac_cmd_regs.sv
module qdac_cmd_regs
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exec_go,
  input  logic [CMD_W-1:0]         cmd_i,
  input  logic                     lock_hi,
  input  logic                     lock_fall,
  output logic [CH_NUM*CODE_W-1:0] chan_code_o,
  output logic                     upo_o,
  output logic                     sleep_o,
  output logic                     mode_rise_o
);
  logic [CODE_W-1:0] in_q  [CH_NUM];
  logic [CODE_W-1:0] out_q [CH_NUM];
  logic [CODE_W-1:0] in_nx [CH_NUM];
  logic [CODE_W-1:0] out_nx[CH_NUM];
  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code;

  assign op   = op_of(cmd_i);
  assign addr = addr_of(cmd_i);
  assign code = code_of(cmd_i);

  always_comb begin
    in_nx  = in_q;
    out_nx = out_q;
    if (exec_go) begin
      case (op)
        OP_LOAD_IN: in_nx[addr] = code;
        OP_LOAD_UPD: begin
          in_nx[addr] = code;
          out_nx      = in_nx;
        end
        OP_UPDATE, OP_MODE_RISE, OP_MODE_FALL: out_nx = in_q;
        OP_BCAST: begin
          for (int i = 0; i < CH_NUM; i++) begin
            in_nx[i]  = code;
            out_nx[i] = code;
          end
        end
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          in_q[g]  <= '0;
          out_q[g] <= '0;
        end else begin
          in_q[g]  <= in_nx[g];
          out_q[g] <= out_nx[g];
        end
      end
      assign chan_code_o[g*CODE_W +: CODE_W] = out_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upo_o       <= 1'b0;
      mode_rise_o <= 1'b0;
    end else if (exec_go) begin
      case (op)
        OP_UPO_LO:    upo_o       <= 1'b0;
        OP_UPO_HI:    upo_o       <= 1'b1;
        OP_MODE_RISE: mode_rise_o <= 1'b1;
        OP_MODE_FALL: mode_rise_o <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_o <= 1'b0;
    end else if (lock_fall) begin
      sleep_o <= 1'b0;
    end else if (exec_go) begin
      case (op)
        OP_SLEEP:          if (lock_hi) sleep_o <= 1'b1;
        OP_UPDATE, OP_BCAST: sleep_o <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     csn_i,
  input  logic                     sdi_i,
  input  logic                     lock_n_i,
  output logic                     sdo_o,
  output logic                     upo_o,
  output logic                     sleep_o,
  output logic [CH_NUM*CODE_W-1:0] chan_code_o
);
  localparam int SIG_N = 4;  // {lock, sdi, csn, sclk}
  localparam logic [SIG_N-1:0] SIG_IDLE = 4'b1010;

  logic [SIG_N-1:0] pin_s;
  logic [2:0]       hist_q;  // {lock, csn, sclk} one cycle back
  logic             s_sclk, s_csn, s_sdi, s_lock;
  logic             sclk_rise, sclk_fall, cs_rise, lock_fall;
  logic             frame_end, exec_go, mode_rise;
  logic [CMD_W-1:0] cmd;

  qdac_sync #(.W(SIG_N), .STAGES(SYNC_STAGES), .RST_VAL(SIG_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({lock_n_i, sdi_i, csn_i, sclk_i}),
    .q_o(pin_s)
  );

  assign {s_lock, s_sdi, s_csn, s_sclk} = pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 3'b110;
    else        hist_q <= {s_lock, s_csn, s_sclk};
  end

  assign sclk_rise = s_sclk & ~hist_q[0];
  assign sclk_fall = ~s_sclk & hist_q[0];
  assign cs_rise   = s_csn & ~hist_q[1];
  assign lock_fall = ~s_lock & hist_q[2];
  assign frame_end = cs_rise;

  qdac_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_high(s_csn), .cs_rise(cs_rise), .sdi(s_sdi),
    .mode_rise(mode_rise),
    .cmd_o(cmd), .frame_ok_o(exec_go), .sdo_o(sdo_o)
  );

  qdac_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .exec_go(exec_go), .cmd_i(cmd),
    .lock_hi(s_lock), .lock_fall(lock_fall),
    .chan_code_o(chan_code_o), .upo_o(upo_o),
    .sleep_o(sleep_o), .mode_rise_o(mode_rise)
  );
endmodule

// File: rtl/qdac_ctrl_chk.sv
module qdac_ctrl_chk #(
  parameter int CW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_go,
  input logic          frame_end,
  input logic          lock_hi,
  input logic          lock_fall,
  input logic          sclk_fall,
  input logic          mode_rise,
  input logic          sdo,
  input logic          upo,
  input logic          sleep,
  input logic [CW-1:0] chan_code
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_go |=> $stable(chan_code));  // R1
  AST_UPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_go |=> $stable(upo));  // R6
  AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(exec_go && lock_hi));  // R4
  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> $past(exec_go || lock_fall));  // R5
  AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !exec_go && !lock_fall) |=>
      ($stable(chan_code) && $stable(upo) && $stable(sleep)));  // R9
  AST_FALL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rise && $past(!mode_rise) && !$past(sclk_fall)) |-> $stable(sdo));  // R8
endmodule

bind qdac_ctrl qdac_ctrl_chk #(.CW(qdac_pkg::CH_NUM*qdac_pkg::CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_go(exec_go), .frame_end(frame_end),
  .lock_hi(s_lock), .lock_fall(lock_fall), .sclk_fall(sclk_fall),
  .mode_rise(mode_rise), .sdo(sdo_o), .upo(upo_o), .sleep(sleep_o),
  .chan_code(chan_code_o)
);

// File: tb/qdac_ctrl_test.sv
module qdac_ctrl_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;  // system clocks per serial half period

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, lock_n = 1'b1;
  logic sdo, upo, sleep;
  logic [39:0] codes;

  logic [9:0]  in_m [4];
  logic [9:0]  out_m[4];
  logic        upo_m, mode1_m, sleep_m;
  logic [15:0] sh_m;
  logic        hi0, lo0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  qdac_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .lock_n_i(lock_n), .sdo_o(sdo), .upo_o(upo), .sleep_o(sleep),
    .chan_code_o(codes)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < 4; i++)
      chk(req, $sformatf("channel %0d code", i), int'(codes[i*10 +: 10]), int'(out_m[i]));
    chk(req, "logic output", int'(upo), int'(upo_m));
    chk(req, "sleep", int'(sleep), int'(sleep_m));
  endtask

  function automatic logic [15:0] mk(input int a, input int c, input int d, input int s);
    return {a[1:0], c[1:0], d[9:0], s[1:0]};
  endfunction

  // reference: control bit C0 set means a channel load
  task automatic model(input logic [15:0] w);
    logic [1:0] a;
    logic [9:0] d;
    a = w[15:14];
    d = w[11:2];
    if (w[12]) begin
      in_m[a] = d;
      if (w[13]) for (int i = 0; i < 4; i++) out_m[i] = in_m[i];
    end else begin
      case (w[15:12])
        4'h4: begin for (int i = 0; i < 4; i++) out_m[i] = in_m[i]; sleep_m = 1'b0; end
        4'h8: begin for (int i = 0; i < 4; i++) begin in_m[i] = d; out_m[i] = d; end sleep_m = 1'b0; end
        4'hC: if (lock_n) sleep_m = 1'b1;
        4'h2: upo_m = 1'b0;
        4'h6: upo_m = 1'b1;
        4'hA: begin mode1_m = 1'b1; for (int i = 0; i < 4; i++) out_m[i] = in_m[i]; end
        4'hE: begin mode1_m = 1'b0; for (int i = 0; i < 4; i++) out_m[i] = in_m[i]; end
        default: ;
      endcase
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    logic exp_hi, exp_lo;
    exp_hi = mode1_m ? sh_m[14] : sh_m[15];
    exp_lo = sh_m[14];
    csn = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      if (i == 0) hi0 = sdo;
      sclk = 1'b0;
      tick(HALF);
      if (i == 0) lo0 = sdo;
      sh_m = {sh_m[14:0], sdi};
    end
    csn = 1'b1;
    tick(2*HALF);
    chk("R8", "echo after first rise", int'(hi0), int'(exp_hi));
    chk("R8", "echo after first fall", int'(lo0), int'(exp_lo));
    if (n == 16) model(w);
  endtask

  task automatic set_lock(input logic v);
    if (lock_n && !v && sleep_m) sleep_m = 1'b0;
    lock_n = v;
    tick(8);
  endtask

  task automatic do_reset();
    lock_n = 1'b1;
    rst_n = 1'b0;
    sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    tick(3);
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; out_m[i] = '0; end
    upo_m = 1'b0; mode1_m = 1'b0; sleep_m = 1'b0; sh_m = '0;
    check_state("R10");
    chk("R10", "echo in clear", int'(sdo), 0);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd2718);
    do_reset();

    // R1: staged loads leave live codes alone
    send(mk(0, 1, 10'h155, 0), 16); check_state("R1");
    send(mk(1, 1, 10'h3FF, 0), 16);
    send(mk(2, 1, 10'h001, 0), 16);
    send(mk(3, 1, 10'h200, 0), 16); check_state("R1");
    // R3: transfer all
    send(mk(1, 0, 10'h0F0, 0), 16); check_state("R3");
    // R2: load plus transfer uses the new value
    send(mk(2, 3, 10'h0AA, 0), 16); check_state("R2");
    // R3: broadcast
    send(mk(2, 0, 10'h123, 0), 16); check_state("R3");
    // R4: sleep vetoed by lockout low, then accepted
    set_lock(1'b0);
    send(mk(3, 0, 10'h000, 0), 16); check_state("R4");
    set_lock(1'b1);
    send(mk(3, 0, 10'h000, 0), 16); check_state("R4");
    send(mk(0, 1, 10'h2AB, 0), 16); check_state("R4");
    // R5: lockout fall wakes with codes kept
    set_lock(1'b0); check_state("R5");
    set_lock(1'b1);
    send(mk(3, 0, 10'h000, 0), 16); check_state("R4");
    send(mk(1, 0, 10'h000, 0), 16); check_state("R3");
    // R6: logic output and no-op
    send(mk(1, 2, 10'h000, 0), 16); check_state("R6");
    send(mk(0, 0, 10'h3FF, 3), 16); check_state("R6");
    send(mk(0, 2, 10'h000, 0), 16); check_state("R6");
    // R7 / R8: echo edge modes
    send(mk(0, 1, 10'h3C3, 0), 16);
    send(mk(2, 2, 10'h000, 0), 16); check_state("R7");
    send(mk(1, 1, 10'h2D2, 0), 16);
    send(mk(3, 2, 10'h000, 0), 16); check_state("R7");
    send(mk(1, 1, 10'h0D2, 1), 16);
    // R11: sub-bits ignored
    send(mk(3, 3, 10'h155, 3), 16); check_state("R11");
    // R9: wrong-length frames discarded
    send(mk(0, 3, 10'h3FF, 0), 15); check_state("R9");
    send(mk(0, 3, 10'h3FF, 0), 17); check_state("R9");
    send(mk(1, 2, 10'h000, 0), 1);  check_state("R9");
    // R10: clear in the middle, rising mode first
    send(mk(2, 2, 10'h000, 0), 16);
    send(mk(1, 2, 10'h000, 0), 16);
    do_reset();
    send(mk(0, 1, 10'h1E1, 0), 16); check_state("R10");
    send(mk(0, 0, 10'h000, 0), 16);

    // random mix
    for (int k = 0; k < 90; k++) begin
      int unsigned r;
      int nb;
      logic [15:0] w;
      r = $urandom % 16;
      w = 16'($urandom);
      if (r < 6) w[12] = 1'b1;
      else begin
        w[12] = 1'b0;
        w[15:13] = 3'($urandom);
      end
      nb = ($urandom % 8 == 0) ? 14 + int'($urandom % 5) : 16;
      if ($urandom % 10 == 0) set_lock(~lock_n);
      send(w, nb);
      check_state(nb == 16 ? "R1" : "R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule